// File: doc/BRIEF.md
# Eight-Pin GPIO Port Controller with Atomic Bit Update

This block is the register-side controller for one general-purpose I/O port of eight pins. It sits on a simple synchronous register bus with a byte offset, a write strobe, a 32-bit write word, a read strobe and a registered read word. For each pin it keeps a direction bit, an output latch bit, a pull-up enable bit and a pin-function code. It also keeps a copy of the pin levels taken when reset is released. Software can change direction and output together through one combined data word, or it can raise or drop single output bits without a read-modify-write, through separate set and clear offsets.

Incoming pin levels pass through a two-stage synchronizer before anything can read them. The pad side gets an output value and an output enable for each pin. The enable is active only for a pin that is set as an output and is in GPIO mode. For any other pin the pad is left undriven, and the function code and a GPIO-mode flag go out to the alternate-function logic outside this block. A build parameter removes the pull-up control for port instances that have no pull-ups.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset, every pin is an input, the output latch is 0, every function code is 0 (GPIO), and every pull-up enable is 1 when pull-up control is present.
- R2: Offset 0x00 is read/write and holds the function codes, two bits per pin, with pin i at bits [2i+1:2i]. Code 0 selects GPIO. The `func_sel` output carries the codes and `gpio_mode[i]` is 1 exactly when pin i has code 0.
- R3: Offset 0x20 is the data word. Bits [31:24] are direction (1 = output) and bits [23:16] are the output latch, and a write loads both. On a write, bits [15:0] are ignored.
- R4: A write to offset 0x24 sets each output latch bit whose matching bit in [23:16] is 1. Latch bits written with 0 keep their value. Reading 0x24 returns 0.
- R5: A write to offset 0x28 clears each output latch bit whose matching bit in [23:16] is 1. Latch bits written with 0 keep their value. Reading 0x28 returns 0.
- R6: Bits [7:0] of the data word return the pin levels after two synchronizer flops. A level that has been held for three clocks is readable.
- R7: Bits [15:8] of the data word return the synchronized pin levels from the first clock after reset is released. Later pin changes and later writes leave these bits unchanged.
- R8: `pad_oe[i]` is 1 exactly when pin i is an output and is in GPIO mode. `pad_out[i]` equals the latch bit when `pad_oe[i]` is 1 and is 0 otherwise.
- R9: Offset 0x2C bits [7:0] are the pull-up enables (1 = enabled) and drive `pull_en`. With `HAS_PULLUP` = 0, a read returns 0, writes have no effect and `pull_en` stays 0.
- R10: `rd_data` updates on the clock after `rd_en` is sampled high and otherwise keeps its value. Offsets that are not mapped read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | 6 | Register byte offset |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write word |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Registered read word |
| pin_in | input | 8 | Pin levels from the pads (asynchronous) |
| pad_out | output | 8 | Value to drive on each pad |
| pad_oe | output | 8 | Pad output enable; 0 leaves the pad undriven |
| pull_en | output | 8 | Pull-up enable for each pin |
| func_sel | output | 16 | Function code for each pin |
| gpio_mode | output | 8 | 1 where the pin is in GPIO mode |

## Verification
The output latch is driven through a direct data write, a set mask, a set with an all-zero mask, and a clear followed by a set that rewrites only the low nibble. Each result is compared with a model, which separates a true bitwise merge from an overwrite and shows which field carries the mask. The pins are held at one pattern through reset and then moved to a different one, so a read that shows both the snapshot and the live value exposes any mix-up between the two fields. A non-GPIO code on a single output pin checks that the enable is gated per pin and not for the whole port. A second instance built without pull-up control runs the same traffic, and its reads and `pull_en` are compared with the first.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int unsigned REG_W     = 32;
  localparam int unsigned DIR_LSB   = 24;
  localparam int unsigned LATCH_LSB = 16;
  localparam int unsigned SNAP_LSB  = 8;
  localparam int unsigned LIVE_LSB  = 0;

  localparam logic [7:0] OFF_FUNC  = 8'h00;
  localparam logic [7:0] OFF_DATA  = 8'h20;
  localparam logic [7:0] OFF_SET   = 8'h24;
  localparam logic [7:0] OFF_CLR   = 8'h28;
  localparam logic [7:0] OFF_PULL  = 8'h2C;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned PIN_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PIN_W-1:0] pin_in,
  output logic [PIN_W-1:0] live,
  output logic [PIN_W-1:0] snap
);
  logic [PIN_W-1:0] stage1, stage2, snap_q;
  logic             taken_q;

  // Synchronizer flops are left unreset so that they track the pins during reset.
  always_ff @(posedge clk) begin
    stage1 <= pin_in;
    stage2 <= stage1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      snap_q  <= '0;
      taken_q <= 1'b0;
    end else if (!taken_q) begin
      snap_q  <= stage2;
      taken_q <= 1'b1;
    end
  end

  assign live = stage2;
  assign snap = snap_q;

  // R7: once captured, the snapshot never moves
  a_r7_snap_frozen: assert property (@(posedge clk) disable iff (rst)
    taken_q |=> $stable(snap_q));
endmodule

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
  import gpio_pkg::*;
#(
  parameter int unsigned PIN_W      = 8,
  parameter int unsigned FSEL_W     = 2,
  parameter int unsigned ADDR_W     = 6,
  parameter bit          HAS_PULLUP = 1'b1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [REG_W-1:0]        wr_data,
  output logic [PIN_W-1:0]        dir,
  output logic [PIN_W-1:0]        latch,
  output logic [PIN_W-1:0]        pull,
  output logic [PIN_W*FSEL_W-1:0] fsel
);
  localparam int unsigned FS_BITS = PIN_W * FSEL_W;
  localparam logic [ADDR_W-1:0] A_FUNC = ADDR_W'(OFF_FUNC);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFF_DATA);
  localparam logic [ADDR_W-1:0] A_SET  = ADDR_W'(OFF_SET);
  localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(OFF_CLR);
  localparam logic [ADDR_W-1:0] A_PULL = ADDR_W'(OFF_PULL);

  logic [PIN_W-1:0]   dir_q, latch_q;
  logic [FS_BITS-1:0] fsel_q;
  logic [PIN_W-1:0]   mask;

  assign mask = wr_data[LATCH_LSB +: PIN_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q   <= '0;
      latch_q <= '0;
      fsel_q  <= '0;
    end else if (wr_en) begin
      case (addr)
        A_FUNC: fsel_q <= wr_data[FS_BITS-1:0];
        A_DATA: begin
          dir_q   <= wr_data[DIR_LSB +: PIN_W];
          latch_q <= mask;
        end
        A_SET:  latch_q <= latch_q | mask;
        A_CLR:  latch_q <= latch_q & ~mask;
        default: ;
      endcase
    end
  end

  generate
    if (HAS_PULLUP) begin : g_pull
      logic [PIN_W-1:0] pull_q;
      always_ff @(posedge clk) begin
        if (rst)                           pull_q <= '1;
        else if (wr_en && addr == A_PULL)  pull_q <= wr_data[PIN_W-1:0];
      end
      assign pull = pull_q;
    end else begin : g_nopull
      assign pull = '0;
    end
  endgenerate

  assign dir   = dir_q;
  assign latch = latch_q;
  assign fsel  = fsel_q;

  a_r1_reset_values: assert property (@(posedge clk)
    $fell(rst) |-> (dir_q == '0 && latch_q == '0 && fsel_q == '0));

  a_r4_set_merges: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == A_SET) |=> (latch_q == ($past(latch_q) | $past(mask))));

  a_r5_clr_merges: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == A_CLR) |=> (latch_q == ($past(latch_q) & ~$past(mask))));
endmodule

// File: rtl/gpio_pad_ctl.sv
module gpio_pad_ctl #(
  parameter int unsigned PIN_W  = 8,
  parameter int unsigned FSEL_W = 2
) (
  input  logic [PIN_W-1:0]        dir,
  input  logic [PIN_W-1:0]        latch,
  input  logic [PIN_W*FSEL_W-1:0] fsel,
  output logic [PIN_W-1:0]        gpio_mode,
  output logic [PIN_W-1:0]        pad_oe,
  output logic [PIN_W-1:0]        pad_out
);
  localparam logic [FSEL_W-1:0] GPIO_CODE = '0;

  generate
    for (genvar i = 0; i < PIN_W; i++) begin : g_pin
      assign gpio_mode[i] = (fsel[i*FSEL_W +: FSEL_W] == GPIO_CODE);
      assign pad_oe[i]    = dir[i] & gpio_mode[i];
      assign pad_out[i]   = latch[i] & pad_oe[i];
    end
  endgenerate
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_pkg::*;
#(
  parameter int unsigned PIN_W      = 8,
  parameter int unsigned FSEL_W     = 2,
  parameter int unsigned ADDR_W     = 6,
  parameter bit          HAS_PULLUP = 1'b1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    wr_en,
  input  logic [31:0]             wr_data,
  input  logic                    rd_en,
  output logic [31:0]             rd_data,
  input  logic [PIN_W-1:0]        pin_in,
  output logic [PIN_W-1:0]        pad_out,
  output logic [PIN_W-1:0]        pad_oe,
  output logic [PIN_W-1:0]        pull_en,
  output logic [PIN_W*FSEL_W-1:0] func_sel,
  output logic [PIN_W-1:0]        gpio_mode
);
  localparam logic [ADDR_W-1:0] A_FUNC = ADDR_W'(OFF_FUNC);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFF_DATA);
  localparam logic [ADDR_W-1:0] A_PULL = ADDR_W'(OFF_PULL);

  logic [PIN_W-1:0]        live, snap, dir, latch, pull;
  logic [PIN_W*FSEL_W-1:0] fsel;
  logic [31:0]             rd_mux, rd_q;

  gpio_in_sync #(.PIN_W(PIN_W)) u_sync (
    .clk(clk), .rst(rst), .pin_in(pin_in), .live(live), .snap(snap));

  gpio_cfg_regs #(.PIN_W(PIN_W), .FSEL_W(FSEL_W), .ADDR_W(ADDR_W),
                  .HAS_PULLUP(HAS_PULLUP)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .dir(dir), .latch(latch), .pull(pull), .fsel(fsel));

  gpio_pad_ctl #(.PIN_W(PIN_W), .FSEL_W(FSEL_W)) u_pad (
    .dir(dir), .latch(latch), .fsel(fsel),
    .gpio_mode(gpio_mode), .pad_oe(pad_oe), .pad_out(pad_out));

  always_comb begin
    rd_mux = '0;
    case (addr)
      A_FUNC: rd_mux[PIN_W*FSEL_W-1:0] = fsel;
      A_DATA: begin
        rd_mux[DIR_LSB   +: PIN_W] = dir;
        rd_mux[LATCH_LSB +: PIN_W] = latch;
        rd_mux[SNAP_LSB  +: PIN_W] = snap;
        rd_mux[LIVE_LSB  +: PIN_W] = live;
      end
      A_PULL: rd_mux[PIN_W-1:0] = pull;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_q <= '0;
    else if (rd_en) rd_q <= rd_mux;
  end

  assign rd_data  = rd_q;
  assign pull_en  = pull;
  assign func_sel = fsel;

  a_r8_oe_needs_gpio: assert property (@(posedge clk) disable iff (rst)
    (pad_oe & ~gpio_mode) == '0);

  a_r8_oe_needs_dir: assert property (@(posedge clk) disable iff (rst)
    (pad_oe & ~dir) == '0);

  a_r10_rdata_hold: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));
endmodule

// File: tb/gpio_port_ctrl_tb.sv
`timescale 1ns/1ps
module gpio_port_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  addr = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [7:0]  pin_in = 8'hA5;
  logic [31:0] rd_data, rd_data_np;
  logic [7:0]  pad_out, pad_oe, pull_en, gpio_mode;
  logic [7:0]  pad_out_np, pad_oe_np, pull_en_np, gpio_mode_np;
  logic [15:0] func_sel, func_sel_np;

  int checks = 0, fails = 0;
  bit done = 0;
  logic rd_q = 1'b0;

  logic [31:0] exp_q[$];
  logic [5:0]  adr_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  gpio_port_ctrl u_dut (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .pin_in(pin_in), .pad_out(pad_out),
    .pad_oe(pad_oe), .pull_en(pull_en), .func_sel(func_sel), .gpio_mode(gpio_mode));

  gpio_port_ctrl #(.HAS_PULLUP(1'b0)) u_dut_np (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data_np), .pin_in(pin_in), .pad_out(pad_out_np),
    .pad_oe(pad_oe_np), .pull_en(pull_en_np), .func_sel(func_sel_np),
    .gpio_mode(gpio_mode_np));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [5:0] a, logic [31:0] exp, string tag);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    exp_q.push_back(exp); adr_q.push_back(a); tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  always @(posedge clk) rd_q <= rd_en;

  // Monitor: pop the scoreboard on the cycle after each sampled read.
  always @(negedge clk) begin
    if (rd_q && exp_q.size() > 0) begin
      logic [31:0] e;
      logic [5:0]  a;
      string       t;
      e = exp_q.pop_front(); a = adr_q.pop_front(); t = tag_q.pop_front();
      chk(t, rd_data, e);
      chk({t, " R9 no-pullup copy"}, rd_data_np, (a == 6'h2C) ? 32'h0 : e);
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state at the pad side
    chk("R1 pad_oe", {24'h0, pad_oe}, 32'h0);
    chk("R1 pull_en", {24'h0, pull_en}, 32'hFF);
    chk("R1 func_sel", {16'h0, func_sel}, 32'h0);
    chk("R2 gpio_mode", {24'h0, gpio_mode}, 32'hFF);
    chk("R9 pull_en absent", {24'h0, pull_en_np}, 32'h0);
    rd(6'h20, 32'h0000_A5A5, "R1 R7 R6 data after reset");
    rd(6'h2C, 32'h0000_00FF, "R1 pull-up reset");
    rd(6'h00, 32'h0, "R1 func reset");

    pin_in = 8'h3C;
    repeat (4) @(negedge clk);
    rd(6'h20, 32'h0000_A53C, "R6 R7 live moves, snapshot holds");

    wr(6'h20, 32'hFFF7_1234);
    rd(6'h20, 32'hFFF7_A53C, "R3 data write, low half ignored");
    chk("R8 pad_oe all out", {24'h0, pad_oe}, 32'hFF);
    chk("R8 pad_out", {24'h0, pad_out}, 32'hF7);

    wr(6'h24, 32'h0008_0000);
    rd(6'h20, 32'hFFFF_A53C, "R4 set bit 3");
    wr(6'h24, 32'hFF00_FFFF);
    rd(6'h20, 32'hFFFF_A53C, "R4 zero mask no change");
    wr(6'h28, 32'h000F_0000);
    rd(6'h20, 32'hFFF0_A53C, "R5 clear low nibble");
    wr(6'h24, 32'h000C_0000);
    rd(6'h20, 32'hFFFC_A53C, "R4 low nibble to C");
    rd(6'h24, 32'h0, "R4 set reads zero");
    rd(6'h28, 32'h0, "R5 clear reads zero");

    wr(6'h00, 32'h0000_0030);
    rd(6'h00, 32'h0000_0030, "R2 func readback");
    chk("R2 gpio_mode pin2", {24'h0, gpio_mode}, 32'hFB);
    chk("R2 func_sel out", {16'h0, func_sel}, 32'h30);
    chk("R8 pad_oe gated", {24'h0, pad_oe}, 32'hFB);
    chk("R8 pad_out gated", {24'h0, pad_out}, 32'hF8);

    wr(6'h2C, 32'hFFFF_FF0F);
    rd(6'h2C, 32'h0000_000F, "R9 pull-up write");
    chk("R9 pull_en", {24'h0, pull_en}, 32'h0F);
    chk("R9 pull_en absent after write", {24'h0, pull_en_np}, 32'h0);

    rd(6'h14, 32'h0, "R10 unmapped reads zero");
    @(negedge clk);
    chk("R10 rd_data holds", rd_data, 32'h0);

    wr(6'h20, 32'h00AA_0000);
    chk("R8 inputs do not drive", {24'h0, pad_oe}, 32'h0);
    chk("R8 pad_out low when off", {24'h0, pad_out}, 32'h0);
    pin_in = 8'h81;
    repeat (4) @(negedge clk);
    rd(6'h20, 32'h00AA_A581, "R7 snapshot survives writes and pin changes");
    repeat (3) @(negedge clk);

    done = 1;
    finish_run();
  end
endmodule